// File: doc/BRIEF.md
# Programmable tap-select timer counter

This block is a 24-stage binary divider clocked by the falling edge of a count clock. One stage of the upper sixteen is routed to a single tap output through a 4-bit select. The tap output gives a square wave at the count clock frequency divided by a power of two. All 24 stages are brought out for observation.

A skip input removes the lowest eight stages from the chain, which shortens every division ratio by a factor of 256. A hold input freezes the count without stopping the clock. Two level inputs, preset and clear, override the counter immediately. Clear empties every stage and drives the tap low. Preset empties every stage and drives the tap high through a conditioning latch. Once preset is released, one falling edge is spent lowering the tap before counting begins. When skip, preset and clear are all high, the chain splits into three independent 8-stage sections that count in parallel. This mode is used to exercise the stages quickly.

Top module: `tapdiv_top`

## Requirements
- R1: While clear is high and the split condition (skip, preset and clear all high) is absent, all stages read 0 and the tap reads 0. This takes effect without waiting for a clock edge.
- R2: While preset is high and clear is low, all stages read 0 and the tap reads 1.
- R3: After preset is released, the first falling count-clock edge drives the tap to 0 and leaves every stage at 0, even if hold is high. Counting starts from the second edge.
- R4: With skip, hold, preset and clear low, and the conditioning latch empty, the 24-bit stage vector increments by one on each falling count-clock edge.
- R5: With skip high outside split mode, stages 0 to 7 keep their value. Stages 8 to 23 then behave as a 16-bit counter that increments on each falling edge.
- R6: When no forcing condition is active, the tap equals stage 8 + select, in both chained and skip operation.
- R7: While hold is high, no stage changes on a falling edge. Counting resumes on the first falling edge after hold goes low.
- R8: In split mode, stages 0-7, 8-15 and 16-23 each increment by one modulo 256 on every falling edge when hold is low. No carry passes between the sections.
- R9: With preset and clear both high and skip low, clear wins: all stages read 0 and the tap reads 0.
- R10: With skip high and select 0, the tap toggles on every falling edge, giving a 50% duty-cycle square wave at half the count-clock rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnt_clk_i | input | 1 | Count clock; stages advance on its falling edge |
| set_i | input | 1 | Preset: clears stages, forces tap high, arms the conditioning latch |
| reset_i | input | 1 | Clear: clears stages and latch, forces tap low (has priority over preset) |
| skip_i | input | 1 | Removes stages 0-7 from the chain; with preset and clear it selects split mode |
| hold_i | input | 1 | Freezes all stages while high |
| sel_i | input | 4 | Selects stage 8 + sel_i as the tap |
| tap_o | output | 1 | Selected stage or forced level |
| stages_o | output | 24 | Current contents of all stages |

## Verification
Preset and clear can be high in the same cycle. The bench provokes this with skip low and expects clear to win (tap low, stages empty). It then raises skip in the same overlap and expects split counting. A second overlap is the release of preset together with an active hold. The first edge must still empty the latch while the stages stay frozen. A reference model in the bench predicts stages and tap for every cycle, and a scoreboard compares them.

// File: rtl/tapdiv_pkg.sv
package tapdiv_pkg;

    typedef enum logic [1:0] {
        MODE_CHAIN = 2'd0,
        MODE_SKIP  = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_CLEAR = 2'd3
    } tapdiv_mode_e;

    typedef struct packed {
        logic latch;
    } tapdiv_cond_t;

endpackage

// File: rtl/tapdiv_mode.sv
module tapdiv_mode
    import tapdiv_pkg::*;
(
    input  logic         set_i,
    input  logic         reset_i,
    input  logic         skip_i,
    output tapdiv_mode_e mode_o,
    output logic         clr_stage_o,
    output logic         arm_o,
    output logic         disarm_o
);

    logic split;

    always_comb begin
        split = skip_i & set_i & reset_i;
        if (split) begin
            mode_o = MODE_SPLIT;
        end else if (set_i | reset_i) begin
            mode_o = MODE_CLEAR;
        end else if (skip_i) begin
            mode_o = MODE_SKIP;
        end else begin
            mode_o = MODE_CHAIN;
        end
        clr_stage_o = (set_i | reset_i) & ~split;
        disarm_o    = reset_i & ~split;
        arm_o       = set_i & ~reset_i;
    end

endmodule

// File: rtl/tapdiv_section.sv
module tapdiv_section #(
    parameter int SEC_W = 8
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [SEC_W-1:0] q_o,
    output logic             full_o
);

    typedef struct packed {
        logic [SEC_W-1:0] cnt;
    } sec_state_t;

    localparam logic [SEC_W-1:0] ONE = {{(SEC_W-1){1'b0}}, 1'b1};

    sec_state_t sec_d, sec_q;

    always_comb begin
        sec_d = sec_q;
        if (step_i) begin
            sec_d.cnt = sec_q.cnt + ONE;
        end
    end

    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end

    assign q_o    = sec_q.cnt;
    assign full_o = &sec_q.cnt;

endmodule

// File: rtl/tapdiv_cond.sv
module tapdiv_cond
    import tapdiv_pkg::*;
#(
    parameter int STAGES = 24,
    parameter int SEL_W  = 4
) (
    input  logic              clk_i,
    input  logic              arm_i,
    input  logic              disarm_i,
    input  logic              split_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [STAGES-1:0] stages_i,
    output logic              latch_o,
    output logic              tap_o
);

    localparam int TAPS = 1 << SEL_W;

    tapdiv_cond_t cond_d, cond_q;
    logic [TAPS-1:0] taps;
    logic            picked;

    always_comb begin
        cond_d = cond_q;
        if (!split_i) begin
            cond_d.latch = 1'b0;
        end
    end

    always_ff @(negedge clk_i or posedge disarm_i or posedge arm_i) begin
        if (disarm_i) begin
            cond_q <= '0;
        end else if (arm_i) begin
            cond_q <= '{latch: 1'b1};
        end else begin
            cond_q <= cond_d;
        end
    end

    always_comb begin
        taps   = stages_i[STAGES-1 -: TAPS];
        picked = taps[sel_i];
        if (disarm_i) begin
            tap_o = 1'b0;
        end else if (arm_i | cond_q.latch) begin
            tap_o = 1'b1;
        end else begin
            tap_o = picked;
        end
    end

    assign latch_o = cond_q.latch;

endmodule

// File: rtl/tapdiv_top.sv
module tapdiv_top
    import tapdiv_pkg::*;
#(
    parameter int SEC_W = 8,
    parameter int N_SEC = 3,
    parameter int SEL_W = 4
) (
    input  logic                   cnt_clk_i,
    input  logic                   set_i,
    input  logic                   reset_i,
    input  logic                   skip_i,
    input  logic                   hold_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic                   tap_o,
    output logic [SEC_W*N_SEC-1:0] stages_o
);

    localparam int STAGES   = SEC_W * N_SEC;
    localparam int TAPS     = 1 << SEL_W;
    localparam int TAP_BASE = STAGES - TAPS;
    localparam int SKIP_SEC = TAP_BASE / SEC_W;

    tapdiv_mode_e       mode;
    logic               clr_stage;
    logic               arm;
    logic               disarm;
    logic               latch_q;
    logic               split;
    logic               skip_on;
    logic               run;
    logic [N_SEC-1:0]   cin;
    logic [N_SEC-1:0]   base;
    logic [N_SEC-1:0]   full;
    logic [N_SEC-1:0]   carry;
    logic [STAGES-1:0]  stages;

    tapdiv_mode u_mode (
        .set_i       (set_i),
        .reset_i     (reset_i),
        .skip_i      (skip_i),
        .mode_o      (mode),
        .clr_stage_o (clr_stage),
        .arm_o       (arm),
        .disarm_o    (disarm)
    );

    assign split   = (mode == MODE_SPLIT);
    assign skip_on = (mode == MODE_SKIP);
    assign run     = ~hold_i & (split | ~latch_q);

    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        localparam bit BELOW = (s < SKIP_SEC);
        localparam bit AT    = (s == SKIP_SEC);

        if (s == 0) begin : g_first
            assign base[s] = 1'b1;
        end else begin : g_next
            assign base[s] = carry[s-1];
        end

        assign cin[s] = split |
                        (skip_on ? (AT ? 1'b1 : (BELOW ? 1'b0 : base[s]))
                                 : base[s]);
        assign carry[s] = cin[s] & full[s];

        tapdiv_section #(
            .SEC_W (SEC_W)
        ) u_section (
            .clk_i  (cnt_clk_i),
            .clr_i  (clr_stage),
            .step_i (run & cin[s]),
            .q_o    (stages[s*SEC_W +: SEC_W]),
            .full_o (full[s])
        );
    end

    tapdiv_cond #(
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_cond (
        .clk_i    (cnt_clk_i),
        .arm_i    (arm),
        .disarm_i (disarm),
        .split_i  (split),
        .sel_i    (sel_i),
        .stages_i (stages),
        .latch_o  (latch_q),
        .tap_o    (tap_o)
    );

    assign stages_o = stages;

endmodule

// File: rtl/tapdiv_checker.sv
module tapdiv_checker #(
    parameter int SEC_W = 8,
    parameter int N_SEC = 3,
    parameter int SEL_W = 4
) (
    input logic                   clk_i,
    input logic                   set_i,
    input logic                   reset_i,
    input logic                   skip_i,
    input logic                   hold_i,
    input logic [SEL_W-1:0]       sel_i,
    input logic                   latch_i,
    input logic                   tap_i,
    input logic [SEC_W*N_SEC-1:0] stages_i
);

    localparam int STAGES = SEC_W * N_SEC;

    logic [1:0] seen_q = 2'd0;
    logic       split;

    assign split = skip_i & set_i & reset_i;

    always_ff @(posedge clk_i) begin
        if (seen_q != 2'd3) begin
            seen_q <= seen_q + 2'd1;
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (split)
        reset_i |-> (!tap_i && stages_i == '0)); // R1

    AST_PRESET_RAISES: assert property (@(posedge clk_i) disable iff (reset_i)
        set_i |-> (tap_i && stages_i == '0)); // R2

    AST_PRESET_RELEASE_EDGE: assert property (@(posedge clk_i) disable iff (set_i || reset_i)
        (seen_q == 2'd3 && $past(set_i && !reset_i)) |-> (!tap_i && stages_i == '0)); // R3

    AST_CHAIN_INCREMENT: assert property (@(posedge clk_i) disable iff (set_i || reset_i)
        (seen_q == 2'd3 && !skip_i && !hold_i && $past(!set_i && !reset_i) && !$past(latch_i))
        |-> stages_i == STAGES'($past(stages_i) + 1'b1)); // R4

    AST_SKIP_LOW_FROZEN: assert property (@(posedge clk_i) disable iff (set_i || reset_i)
        (seen_q == 2'd3 && skip_i && $past(!set_i && !reset_i))
        |-> stages_i[SEC_W-1:0] == $past(stages_i[SEC_W-1:0])); // R5

    AST_HOLD_FREEZES: assert property (@(posedge clk_i) disable iff (set_i || reset_i)
        (seen_q == 2'd3 && hold_i && $past(!set_i && !reset_i)) |-> $stable(stages_i)); // R7

    for (genvar s = 0; s < N_SEC; s++) begin : g_split_chk
        AST_SPLIT_SECTION_STEP: assert property (@(posedge clk_i) disable iff (!split)
            (seen_q == 2'd3 && !hold_i && $past(split))
            |-> stages_i[s*SEC_W +: SEC_W] ==
                SEC_W'($past(stages_i[s*SEC_W +: SEC_W]) + 1'b1)); // R8
    end

    AST_SET_CLEAR_PRIORITY: assert property (@(posedge clk_i) disable iff (skip_i)
        (set_i && reset_i) |-> !tap_i); // R9

    AST_FAST_TAP_TOGGLES: assert property (@(posedge clk_i) disable iff (set_i || reset_i)
        (seen_q == 2'd3 && skip_i && !hold_i && sel_i == '0 && $past(sel_i == '0)
         && $past(skip_i) && $past(!set_i && !reset_i) && !$past(latch_i))
        |-> tap_i != $past(tap_i)); // R10

endmodule

bind tapdiv_top tapdiv_checker #(
    .SEC_W (SEC_W),
    .N_SEC (N_SEC),
    .SEL_W (SEL_W)
) u_chk (
    .clk_i    (cnt_clk_i),
    .set_i    (set_i),
    .reset_i  (reset_i),
    .skip_i   (skip_i),
    .hold_i   (hold_i),
    .sel_i    (sel_i),
    .latch_i  (latch_q),
    .tap_i    (tap_o),
    .stages_i (stages_o)
);

// File: tb/tb_tapdiv_top.sv
`timescale 1ns / 1ps
module tb_tapdiv_top;

    typedef struct {
        string       tag;
        logic [23:0] st;
        logic        tap;
    } exp_t;

    logic        clk = 1'b0;
    logic        set_i = 1'b0;
    logic        reset_i = 1'b1;
    logic        skip_i = 1'b0;
    logic        hold_i = 1'b0;
    logic [3:0]  sel_i = 4'd0;
    logic        tap_o;
    logic [23:0] stages_o;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    exp_t        sb[$];
    logic [23:0] m_st = '0;
    logic        m_latch = 1'b0;

    always #2 clk = ~clk;

    tapdiv_top dut (
        .cnt_clk_i (clk),
        .set_i     (set_i),
        .reset_i   (reset_i),
        .skip_i    (skip_i),
        .hold_i    (hold_i),
        .sel_i     (sel_i),
        .tap_o     (tap_o),
        .stages_o  (stages_o)
    );

    // Driver: applies inputs mid-high phase, predicts the state after the next falling edge.
    task automatic step(input string tag, input bit s, input bit r, input bit b,
                        input bit h, input bit [3:0] sl, input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            bit   tst;
            @(posedge clk);
            #0.5;
            set_i   = s;
            reset_i = r;
            skip_i  = b;
            hold_i  = h;
            sel_i   = sl;
            tst = b & s & r;
            if (!tst && r) begin
                m_st = '0;
                m_latch = 1'b0;
            end else if (!tst && s) begin
                m_st = '0;
                m_latch = 1'b1;
            end else if (tst) begin
                if (!h) begin
                    for (int k = 0; k < 3; k++) m_st[k*8 +: 8] = m_st[k*8 +: 8] + 8'd1;
                end
            end else if (m_latch) begin
                m_latch = 1'b0;
            end else if (!h) begin
                if (b) m_st[23:8] = m_st[23:8] + 16'd1;
                else   m_st = m_st + 24'd1;
            end
            e.tag = tag;
            e.st  = m_st;
            if (!tst && r)       e.tap = 1'b0;
            else if (!tst && s)  e.tap = 1'b1;
            else if (m_latch)    e.tap = 1'b1;
            else                 e.tap = m_st[8 + sl];
            sb.push_back(e);
        end
    endtask

    // Monitor: compares just after the rising edge, before the driver moves inputs.
    initial begin
        forever begin
            @(posedge clk);
            #0.25;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (stages_o !== e.st || tap_o !== e.tap) begin
                    errors++;
                    $display("FAIL %s: stages=%h tap=%b expected stages=%h tap=%b",
                             e.tag, stages_o, tap_o, e.st, e.tap);
                end
            end
        end
    end

    initial begin
        #600000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step("R1 clear at start",           0, 1, 0, 0, 4'd0, 3);
        step("R4 chained count",            0, 0, 0, 0, 4'd0, 20);
        step("R7 hold freezes",             0, 0, 0, 1, 4'd0, 6);
        step("R7 resume after hold",        0, 0, 0, 0, 4'd0, 4);
        step("R2 preset forces high",       1, 0, 0, 0, 4'd0, 3);
        step("R3 first edge after preset",  0, 0, 0, 0, 4'd0, 1);
        step("R3 second edge counts",       0, 0, 0, 0, 4'd0, 1);
        step("R6 chained tap sel 0",        0, 0, 0, 0, 4'd0, 600);
        step("R6 chained tap sel 1",        0, 0, 0, 0, 4'd1, 300);
        step("R2 preset again",             1, 0, 0, 0, 4'd0, 2);
        step("R3 release under hold",       0, 0, 0, 1, 4'd0, 2);
        step("R4 count after held release", 0, 0, 0, 0, 4'd0, 2);
        step("R5 skip count sel 0",         0, 0, 1, 0, 4'd0, 40);
        step("R10 skip tap sel 2",          0, 0, 1, 0, 4'd2, 40);
        step("R7 hold in skip",             0, 0, 1, 1, 4'd2, 5);
        step("R9 preset and clear",         1, 1, 0, 0, 4'd0, 3);
        step("R8 split sections",           1, 1, 1, 0, 4'd0, 300);
        step("R8 split under hold",         1, 1, 1, 1, 4'd0, 4);
        step("R9 leave split",              1, 1, 0, 0, 4'd0, 2);
        step("R1 clear with skip",          0, 1, 1, 0, 4'd0, 2);
        step("R6 top tap sel 15",           0, 0, 0, 0, 4'd15, 5);
        while (sb.size() > 0) begin
            @(posedge clk);
            #1;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule